// File: doc/BRIEF.md
# Dual-Bank Glitch-Free Clock Switcher

This block derives one root clock from two identical configuration banks. Each bank picks one of two source rates (a fast rate that ticks every fabric cycle and a slow rate that ticks once every `SLOW_RATIO` cycles) and divides it by an integer. Only the bank named by the active-bank select drives the output. A retune works like this. Software writes the new setting into the idle bank while the live bank keeps running. It then writes the select bit. The switcher first releases the old bank on a low phase of that bank's clock. It passes the enable for the new bank through a two-stage synchronizer, and admits the new bank on a low phase of the new bank's clock. The output therefore never carries a truncated high pulse.

After the handover the switcher waits a fixed number of slow-source ticks so the multiplexer can settle. It then parks the bank that was released: that bank's counter is stopped, its source is set to the slow input and its divider is set to the largest value. While the output is disabled, no bank switch is accepted. The live bank may instead be rewritten in place, and its source is forced to the slow input.

All state is modelled in one fabric clock domain. Each bank's clock exists as a registered level and the output is the gated OR of those levels, which keeps the handshake deterministic and observable.

Top module: `clk_dual_bank_switch`

## Requirements
- R1: After reset `active_bank` is 0, `switch_busy` is 0 and `clk_out` is low; both banks start parked (slow source, divider at maximum, counter off).
- R2: With a bank active, its counter enabled and its reset bit clear, each high phase and each low phase of `clk_out` lasts (div+1) cycles when the bank source field is 0 (fast) and (div+1)*SLOW_RATIO cycles when it is 1 (slow).
- R3: A select write with `out_en` high and a value different from `active_bank` raises `switch_busy` on the next cycle. `active_bank` keeps its old value while busy and shows the new bank once `switch_busy` falls.
- R4: The old bank's gate is removed only while that bank's level is low, and the new bank's gate is applied only while the new bank's level is low. At most one gate is on at any time. During a switch every high pulse of `clk_out` has the full width of either the old or the new setting.
- R5: A select write while `out_en` is low is ignored: `switch_busy` stays low and `active_bank` is unchanged.
- R6: Configuration writes to either bank are dropped while a switch is in progress, from the select toggle until the settle wait ends.
- R7: SETTLE_TICKS slow ticks after the new bank is gated in, the released bank is parked. Switching back to it without rewriting it leaves `clk_out` low.
- R8: When `out_en` is low, `clk_out` is low from the cycle after `out_en` is sampled low onward. A bank whose reset bit is set or whose counter-enable bit is clear produces no clock. When `out_en` returns high, the programmed rate resumes.
- R9: With no switch in progress, a configuration write to the active bank takes effect directly on `clk_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| out_en | input | 1 | Root output enable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_bank | input | 1 | Bank addressed by the write |
| cfg_src | input | 1 | Source select: 0 fast, 1 slow |
| cfg_div | input | DIV_W | Divider value (phase length is div+1 source ticks) |
| cfg_rst | input | 1 | Bank counter reset bit |
| cfg_cnt_en | input | 1 | Bank counter enable bit |
| sel_wr | input | 1 | Bank-select write strobe |
| sel_val | input | 1 | Requested bank |
| clk_out | output | 1 | Switched root clock |
| active_bank | output | 1 | Bank currently driving the output |
| switch_busy | output | 1 | High from the select toggle until the new bank is gated in |

## Verification
The bench builds the block with DIV_W=3, SLOW_RATIO=3, SYNC_STAGES=2 and SETTLE_TICKS=6. With these values it can sweep every divider value on both sources, sixteen settings in all. Each setting is reached through a full bank handover, so the handshake runs in both directions many times. While each switch runs, the bench watches every high pulse and checks it against the two legal widths. The small divider width keeps the slowest phase at 24 cycles, so the parked bank, the dropped writes and the disabled output are all reached within a short run.

// File: rtl/clk_dbs_pkg.sv
package clk_dbs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DROP   = 3'd1,
        ST_SYNC   = 3'd2,
        ST_ARM    = 3'd3,
        ST_SETTLE = 3'd4
    } sw_state_e;

    localparam logic SRC_FAST   = 1'b0;
    localparam logic SRC_SLOW   = 1'b1;
    localparam logic LOWPWR_SRC = SRC_SLOW;
endpackage

// File: rtl/clk_dbs_slow_tick.sv
module clk_dbs_slow_tick #(
    parameter int RATIO = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == CW'(RATIO - 1));
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/clk_dbs_bank_div.sv
module clk_dbs_bank_div
    import clk_dbs_pkg::*;
#(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic             src,
    input  logic [DIV_W-1:0] div,
    input  logic             run,
    output logic             lvl
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             lvl;
    } div_t;

    div_t d, q;
    logic tick;

    always_comb begin
        d    = q;
        tick = (src == SRC_FAST) ? 1'b1 : slow_tick;
        if (!run) begin
            d.cnt = '0;
            d.lvl = 1'b0;
        end else if (tick) begin
            if (q.cnt == div) begin
                d.cnt = '0;
                d.lvl = ~q.lvl;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lvl = q.lvl;

    AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !lvl); // R8
endmodule

// File: rtl/clk_dbs_switch_ctl.sv
module clk_dbs_switch_ctl
    import clk_dbs_pkg::*;
#(
    parameter int DIV_W        = 3,
    parameter int SYNC_STAGES  = 2,
    parameter int SETTLE_TICKS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  out_en,
    input  logic                  cfg_wr,
    input  logic                  cfg_bank,
    input  logic                  cfg_src,
    input  logic [DIV_W-1:0]      cfg_div,
    input  logic                  cfg_rst,
    input  logic                  cfg_cnt_en,
    input  logic                  sel_wr,
    input  logic                  sel_val,
    input  logic                  slow_tick,
    input  logic [1:0]            lvl,
    output logic [1:0]            bank_src,
    output logic [1:0][DIV_W-1:0] bank_div,
    output logic [1:0]            bank_run,
    output logic [1:0]            gate,
    output logic                  active,
    output logic                  busy
);
    localparam int SW = $clog2(SETTLE_TICKS + 1);

    typedef struct packed {
        sw_state_e                 state;
        logic                      active;
        logic [1:0]                gate;
        logic [SYNC_STAGES-1:0]    sync;
        logic [SW-1:0]             settle;
        logic [1:0]                src;
        logic [1:0][DIV_W-1:0]     div;
        logic [1:0]                rst;
        logic [1:0]                cen;
    } ctl_t;

    ctl_t d, q;
    logic other;

    always_comb begin
        d     = q;
        other = ~q.active;
        if (q.state == ST_IDLE && cfg_wr) begin
            d.src[cfg_bank] = cfg_src;
            d.div[cfg_bank] = cfg_div;
            d.rst[cfg_bank] = cfg_rst;
            d.cen[cfg_bank] = cfg_cnt_en;
        end
        case (q.state)
            ST_IDLE: begin
                if (sel_wr && out_en && (sel_val != q.active))
                    d.state = ST_DROP;
            end
            ST_DROP: begin
                if (!lvl[q.active]) begin
                    d.gate[q.active] = 1'b0;
                    d.sync           = '0;
                    d.state          = ST_SYNC;
                end
            end
            ST_SYNC: begin
                d.sync = {q.sync[SYNC_STAGES-2:0], 1'b1};
                if (q.sync[SYNC_STAGES-1])
                    d.state = ST_ARM;
            end
            ST_ARM: begin
                if (!lvl[other]) begin
                    d.gate[other] = 1'b1;
                    d.active      = other;
                    d.settle      = '0;
                    d.state       = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (slow_tick) begin
                    if (q.settle == SW'(SETTLE_TICKS - 1)) begin
                        d.cen[other] = 1'b0;
                        d.rst[other] = 1'b0;
                        d.src[other] = LOWPWR_SRC;
                        d.div[other] = '1;
                        d.state      = ST_IDLE;
                    end else begin
                        d.settle = q.settle + 1'b1;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.state  <= ST_IDLE;
            q.gate   <= 2'b01;
            q.src    <= {2{LOWPWR_SRC}};
            q.div    <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        for (int b = 0; b < 2; b++) begin
            bank_run[b] = out_en & q.cen[b] & ~q.rst[b];
            bank_src[b] = out_en ? q.src[b] : LOWPWR_SRC;
            bank_div[b] = q.div[b];
        end
        gate   = q.gate;
        active = q.active;
        busy   = (q.state == ST_DROP) || (q.state == ST_SYNC) || (q.state == ST_ARM);
    end

    AST_SEL_OFF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && sel_wr && !out_en) |=> !busy); // R5
    AST_WR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_wr) |=> ($stable(q.div) && $stable(q.src) && $stable(q.cen))); // R6
    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(active)); // R3
endmodule

// File: rtl/clk_dual_bank_switch.sv
module clk_dual_bank_switch
    import clk_dbs_pkg::*;
#(
    parameter int DIV_W        = 3,
    parameter int SLOW_RATIO   = 3,
    parameter int SYNC_STAGES  = 2,
    parameter int SETTLE_TICKS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_en,
    input  logic             cfg_wr,
    input  logic             cfg_bank,
    input  logic             cfg_src,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_rst,
    input  logic             cfg_cnt_en,
    input  logic             sel_wr,
    input  logic             sel_val,
    output logic             clk_out,
    output logic             active_bank,
    output logic             switch_busy
);
    logic                  slow_tick;
    logic [1:0]            lvl;
    logic [1:0]            bank_src;
    logic [1:0][DIV_W-1:0] bank_div;
    logic [1:0]            bank_run;
    logic [1:0]            gate;

    clk_dbs_slow_tick #(.RATIO(SLOW_RATIO)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (slow_tick)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        clk_dbs_bank_div #(.DIV_W(DIV_W)) u_div (
            .clk       (clk),
            .rst_n     (rst_n),
            .slow_tick (slow_tick),
            .src       (bank_src[b]),
            .div       (bank_div[b]),
            .run       (bank_run[b]),
            .lvl       (lvl[b])
        );

        AST_GATE_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(gate[b]) |-> !$past(lvl[b])); // R4
        AST_GATE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate[b]) |-> !$past(lvl[b])); // R4
    end

    clk_dbs_switch_ctl #(
        .DIV_W        (DIV_W),
        .SYNC_STAGES  (SYNC_STAGES),
        .SETTLE_TICKS (SETTLE_TICKS)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .out_en     (out_en),
        .cfg_wr     (cfg_wr),
        .cfg_bank   (cfg_bank),
        .cfg_src    (cfg_src),
        .cfg_div    (cfg_div),
        .cfg_rst    (cfg_rst),
        .cfg_cnt_en (cfg_cnt_en),
        .sel_wr     (sel_wr),
        .sel_val    (sel_val),
        .slow_tick  (slow_tick),
        .lvl        (lvl),
        .bank_src   (bank_src),
        .bank_div   (bank_div),
        .bank_run   (bank_run),
        .gate       (gate),
        .active     (active_bank),
        .busy       (switch_busy)
    );

    assign clk_out = |(gate & lvl);

    AST_ONE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate)); // R4
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!out_en) && !out_en) |-> !clk_out); // R8
endmodule

// File: tb/tb_clk_dual_bank_switch.sv
`timescale 1ns/1ps
module tb_clk_dual_bank_switch;
    localparam int DW = 3;
    localparam int SR = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic out_en = 1'b0, cfg_wr = 1'b0, cfg_bank = 1'b0, cfg_src = 1'b0;
    logic [DW-1:0] cfg_div = '0;
    logic cfg_rst = 1'b0, cfg_cnt_en = 1'b0, sel_wr = 1'b0, sel_val = 1'b0;
    logic clk_out, active_bank, switch_busy;

    int n_checks = 0, n_fail = 0;
    int mon_on = 0, mon_a = 0, mon_b = 0, run_len = 0;
    logic cur = 1'b0;

    always #2.5 clk = ~clk;

    clk_dual_bank_switch #(.DIV_W(DW), .SLOW_RATIO(SR), .SYNC_STAGES(2), .SETTLE_TICKS(6)) dut (
        .clk(clk), .rst_n(rst_n), .out_en(out_en), .cfg_wr(cfg_wr), .cfg_bank(cfg_bank),
        .cfg_src(cfg_src), .cfg_div(cfg_div), .cfg_rst(cfg_rst), .cfg_cnt_en(cfg_cnt_en),
        .sel_wr(sel_wr), .sel_val(sel_val), .clk_out(clk_out), .active_bank(active_bank),
        .switch_busy(switch_busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int width(input logic src, input int div);
        return (div + 1) * (src ? SR : 1);
    endfunction

    // R4: every high pulse during a switch is one of the two legal widths
    always @(negedge clk) begin
        if (clk_out) run_len++;
        else begin
            if (run_len != 0 && mon_on != 0)
                check(run_len == mon_a || run_len == mon_b, "R4 pulse width", run_len, mon_a);
            run_len = 0;
        end
    end

    task automatic wr_cfg(input logic b, input logic s, input int dv, input logic r, input logic e);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_bank = b; cfg_src = s; cfg_div = DW'(dv); cfg_rst = r; cfg_cnt_en = e;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic measure(input int exp, input string tag);
        int hi, lo, t;
        hi = 0; lo = 0; t = 0;
        while (clk_out !== 1'b0 && t < 500) begin @(negedge clk); t++; end
        while (clk_out !== 1'b1 && t < 500) begin @(negedge clk); t++; end
        while (clk_out === 1'b1 && t < 500) begin hi++; @(negedge clk); t++; end
        while (clk_out === 1'b0 && t < 500) begin lo++; @(negedge clk); t++; end
        check(hi == exp, {tag, " high phase"}, hi, exp);
        check(lo == exp, {tag, " low phase"}, lo, exp);
    endtask

    task automatic quiet(input int n, input string tag);
        int seen;
        seen = 0;
        for (int i = 0; i < n; i++) begin @(negedge clk); if (clk_out) seen++; end
        check(seen == 0, tag, seen, 0);
    endtask

    task automatic switch_to(input logic tgt, input int w_old, input int w_new, input bit poke);
        int t;
        mon_a = w_old; mon_b = w_new; mon_on = 1;
        @(negedge clk);
        sel_wr = 1'b1; sel_val = tgt;
        @(negedge clk);
        sel_wr = 1'b0;
        check(switch_busy == 1'b1, "R3 busy after select", int'(switch_busy), 1);
        check(active_bank == cur, "R3 active held while busy", int'(active_bank), int'(cur));
        if (poke) begin
            cfg_wr = 1'b1; cfg_bank = tgt; cfg_src = 1'b0; cfg_div = DW'(6); cfg_rst = 1'b0; cfg_cnt_en = 1'b1;
            @(negedge clk);
            cfg_wr = 1'b0;
        end
        t = 0;
        while (switch_busy && t < 1000) begin @(negedge clk); t++; end
        check(active_bank == tgt, "R3 active after switch", int'(active_bank), int'(tgt));
        idle(40);
        mon_on = 0;
        cur = tgt;
    endtask

    initial begin
        int w_cur, w_new;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(active_bank == 1'b0, "R1 reset active bank", int'(active_bank), 0);
        check(switch_busy == 1'b0, "R1 reset busy", int'(switch_busy), 0);
        quiet(20, "R1 reset output low");

        out_en = 1'b1;
        wr_cfg(1'b0, 1'b0, 0, 1'b1, 1'b0);
        wr_cfg(1'b0, 1'b0, 0, 1'b0, 1'b1);
        w_cur = width(1'b0, 0);
        measure(w_cur, "R9 direct write live bank");

        // R2 sweep of every divider on both sources, each via a handover
        for (int i = 0; i < 16; i++) begin
            logic s;
            int dv;
            s = i[3]; dv = i % 8;
            w_new = width(s, dv);
            wr_cfg(~cur, s, dv, 1'b1, 1'b0);
            wr_cfg(~cur, s, dv, 1'b0, 1'b1);
            switch_to(~cur, w_cur, w_new, 1'b0);
            measure(w_new, "R2 divided rate");
            w_cur = w_new;
        end

        // R6: write to the incoming bank during the switch is dropped
        wr_cfg(~cur, 1'b0, 2, 1'b1, 1'b0);
        wr_cfg(~cur, 1'b0, 2, 1'b0, 1'b1);
        switch_to(~cur, w_cur, 3, 1'b1);
        measure(3, "R6 write during switch dropped");
        w_cur = 3;

        // R7: released bank is parked; going back to it gives no clock
        switch_to(~cur, w_cur, w_cur, 1'b0);
        quiet(60, "R7 parked bank silent");

        // R9: rewrite the live bank in place
        wr_cfg(cur, 1'b1, 1, 1'b1, 1'b0);
        wr_cfg(cur, 1'b1, 1, 1'b0, 1'b1);
        measure(width(1'b1, 1), "R9 direct write live bank");

        // R8 / R5: disabled output
        @(negedge clk); out_en = 1'b0;
        @(negedge clk);
        quiet(30, "R8 output low when disabled");
        sel_wr = 1'b1; sel_val = ~cur;
        @(negedge clk);
        sel_wr = 1'b0;
        check(switch_busy == 1'b0, "R5 select ignored busy", int'(switch_busy), 0);
        idle(5);
        check(active_bank == cur, "R5 select ignored bank", int'(active_bank), int'(cur));
        out_en = 1'b1;
        idle(2);
        measure(width(1'b1, 1), "R8 resume after enable");
        wr_cfg(cur, 1'b0, 1, 1'b1, 1'b1);
        idle(1);
        quiet(30, "R8 reset bit stops clock");
        wr_cfg(cur, 1'b0, 1, 1'b0, 1'b0);
        idle(1);
        quiet(30, "R8 counter off stops clock");

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule